// File: doc/BRIEF.md
# UART banked register decoder

This block sits between a simple synchronous register bus and the register port of a 16550-style UART core. Some bus offsets reach different physical registers depending on an access mode. Software picks the mode by writing a value to the line-control offset. The block holds the extended registers itself: an enhanced-feature register, two XON and two XOFF characters, a trigger-control and a trigger-level register, a baud-lock register and an auxiliary control register. Every other access goes to the core's register port, and a select line marks each cycle in which that happens.

The bus has no back-pressure. Each cycle carries at most one access. Write data is taken on the clock edge where `bus_we` is high. Read data appears on `bus_rdata` one cycle after `bus_re` and then holds until the next read. The core port passes address, write data and strobes straight through. It expects the core to present `core_rdata` in the same cycle as `core_re`, and this block registers that value.

Top module: `uart_bank_decoder`

## Requirements
- R1: A write to offset 0x0C sets the mode from its low byte: 0xBF gives config-B, any other byte with bit 7 set gives config-A, and anything else gives operational. The write is always forwarded to the core (core_we high).
- R2: In config-B, offset 0x08 reads and writes the local enhanced-feature register (EFR) and is not forwarded. In the other modes it is forwarded.
- R3: In config-B, offsets 0x10 and 0x14 read and write local XON character 0 and XON character 1, selected by address bit 2, and are not forwarded.
- R4: While EFR bit 4 and the MCR shadow bit 6 are both 1, offset 0x18 is the local trigger-control register and 0x1C the local trigger-level register, in every mode, ahead of the config-B test.
- R5: When the R4 condition is false, offsets 0x18 and 0x1C reach local XOFF character 0 and XOFF character 1 in config-B, and are forwarded in the other modes.
- R6: Offset 0x38 (baud-lock) is local. It reads 0 in either config mode. A write there changes it only in operational mode, and only bits 7:6 are kept (other bits read 0).
- R7: Offset 0x3C (auxiliary control) is local. It reads 0 outside operational mode. A write there takes effect only in operational mode and keeps all 8 bits.
- R8: After reset the block is in operational mode, baud-lock reads 0x40, auxiliary control reads 0, trigger-control holds 0x0F, EFR, MCR shadow, trigger-level and the XON/XOFF characters hold 0, bus_rdata is 0 and core_sel is low.
- R9: A write to offset 0x10 outside config-B is forwarded to the core and also loads the MCR shadow. In config-B it loads the XON character instead and leaves the shadow unchanged.
- R10: bus_rdata changes only on the clock edge of a read cycle, one cycle after bus_re, for local and forwarded reads alike, and then holds. core_sel is low in cycles with no access.
- R11: Offsets that are not handled locally, such as 0x00, 0x04, 0x0C reads and 0x20, are forwarded, with core_sel, core_re/core_we and the core's read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (8) | Registered read data |
| core_sel | output | 1 | High when the current access is forwarded |
| core_addr | output | ADDR_W (8) | Offset passed to the core |
| core_wdata | output | DATA_W (8) | Write data passed to the core |
| core_we | output | 1 | Forwarded write strobe |
| core_re | output | 1 | Forwarded read strobe |
| core_rdata | input | DATA_W (8) | Core read data for the current core_re cycle |

## Verification
Each banked offset is accessed in all three modes. The local registers hold values that differ from what the core model returns, so a wrong route shows up in both the data and core_sel. Line-control bytes 0xBF, 0xBE, 0x80 and 0x3F separate the exact-byte match from a plain bit-7 test. The trigger overlay is switched on and off through the MCR shadow. The bench reads offset 0x18 in config-B while the overlay is on and again while it is off, which shows whether the overlay is checked before the mode. It also writes offset 0x10 in config-B to show that the shadow ignores those writes. Baud-lock and auxiliary-control writes made in a config mode are then read back in operational mode, which shows whether they were dropped.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;

  typedef enum logic [1:0] {
    MODE_OP    = 2'd0,
    MODE_CFG_A = 2'd1,
    MODE_CFG_B = 2'd2
  } acc_mode_e;

  typedef enum logic [3:0] {
    TGT_CORE = 4'd0,
    TGT_EFR  = 4'd1,
    TGT_XON  = 4'd2,
    TGT_XOFF = 4'd3,
    TGT_TCR  = 4'd4,
    TGT_TLR  = 4'd5,
    TGT_BLR  = 4'd6,
    TGT_ACR  = 4'd7,
    TGT_ZERO = 4'd8
  } tgt_e;

  localparam logic [7:0] OFS_EFR   = 8'h08;
  localparam logic [7:0] OFS_LCR   = 8'h0C;
  localparam logic [7:0] OFS_MCR   = 8'h10;
  localparam logic [7:0] OFS_XON1  = 8'h14;
  localparam logic [7:0] OFS_TCR   = 8'h18;
  localparam logic [7:0] OFS_TLR   = 8'h1C;
  localparam logic [7:0] OFS_BLR   = 8'h38;
  localparam logic [7:0] OFS_ACR   = 8'h3C;

  localparam logic [7:0] LCR_KEY_B = 8'hBF;
  localparam int unsigned NCHAR    = 2;
  localparam int unsigned CHAR_IDX_BIT = 2;
  localparam int unsigned EFR_ENH_BIT  = 4;
  localparam int unsigned MCR_TRIG_BIT = 6;

endpackage

// File: rtl/uart_bank_mode.sv
module uart_bank_mode
  import uart_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lcr_wr,
  input  logic [7:0] lcr_byte,
  output acc_mode_e  mode
);

  acc_mode_e mode_q;
  acc_mode_e mode_d;

  always_comb begin
    if (lcr_byte == LCR_KEY_B)  mode_d = MODE_CFG_B;
    else if (lcr_byte[7])       mode_d = MODE_CFG_A;
    else                        mode_d = MODE_OP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      mode_q <= MODE_OP;
    else if (lcr_wr) mode_q <= mode_d;
  end

  assign mode = mode_q;

  AST_MODE_KEY_B: assert property (@(posedge clk) disable iff (!rst_n)
    (lcr_wr && lcr_byte == 8'hBF) |=> (mode == MODE_CFG_B)); // R1
  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (lcr_wr && !lcr_byte[7]) |=> (mode == MODE_OP)); // R1
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lcr_wr |=> $stable(mode)); // R1

endmodule

// File: rtl/uart_bank_route.sv
module uart_bank_route
  import uart_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  acc_mode_e         mode,
  input  logic              efr_enh,
  input  logic              mcr_trig,
  output tgt_e              tgt,
  output logic              idx
);

  localparam logic [ADDR_W-1:0] A_EFR  = ADDR_W'(OFS_EFR);
  localparam logic [ADDR_W-1:0] A_XON0 = ADDR_W'(OFS_MCR);
  localparam logic [ADDR_W-1:0] A_XON1 = ADDR_W'(OFS_XON1);
  localparam logic [ADDR_W-1:0] A_TCR  = ADDR_W'(OFS_TCR);
  localparam logic [ADDR_W-1:0] A_TLR  = ADDR_W'(OFS_TLR);
  localparam logic [ADDR_W-1:0] A_BLR  = ADDR_W'(OFS_BLR);
  localparam logic [ADDR_W-1:0] A_ACR  = ADDR_W'(OFS_ACR);

  logic bank_b;
  logic trig_on;
  logic oper;

  assign bank_b  = (mode == MODE_CFG_B);
  assign oper    = (mode == MODE_OP);
  assign trig_on = efr_enh & mcr_trig;
  assign idx     = addr[CHAR_IDX_BIT];

  always_comb begin
    tgt = TGT_CORE;
    unique case (addr)
      A_EFR:          tgt = bank_b ? TGT_EFR : TGT_CORE;
      A_XON0, A_XON1: tgt = bank_b ? TGT_XON : TGT_CORE;
      A_TCR, A_TLR: begin
        if (trig_on)     tgt = (addr == A_TCR) ? TGT_TCR : TGT_TLR;
        else if (bank_b) tgt = TGT_XOFF;
        else             tgt = TGT_CORE;
      end
      A_BLR:          tgt = oper ? TGT_BLR : TGT_ZERO;
      A_ACR:          tgt = oper ? TGT_ACR : TGT_ZERO;
      default:        tgt = TGT_CORE;
    endcase
  end

endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
  import uart_bank_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  tgt_e              tgt,
  input  logic              idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mcr_snoop,
  output logic [DATA_W-1:0] rd_val,
  output logic              efr_enh,
  output logic              mcr_trig
);

  localparam logic [DATA_W-1:0] BLR_RST  = DATA_W'(8'h40);
  localparam logic [DATA_W-1:0] BLR_MASK = DATA_W'(8'hC0);
  localparam logic [DATA_W-1:0] TCR_RST  = DATA_W'(8'h0F);
  localparam logic [DATA_W-1:0] BYTE_MASK = DATA_W'(8'hFF);

  logic [DATA_W-1:0] efr_q, mcr_q, tcr_q, tlr_q, blr_q, acr_q;
  logic [DATA_W-1:0] xon_q  [NCHAR];
  logic [DATA_W-1:0] xoff_q [NCHAR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      efr_q <= '0;
      tcr_q <= TCR_RST;
      tlr_q <= '0;
      blr_q <= BLR_RST;
      acr_q <= '0;
    end else if (wr_en) begin
      case (tgt)
        TGT_EFR: efr_q <= wdata;
        TGT_TCR: tcr_q <= wdata & BYTE_MASK;
        TGT_TLR: tlr_q <= wdata & BYTE_MASK;
        TGT_BLR: blr_q <= wdata & BLR_MASK;
        TGT_ACR: acr_q <= wdata & BYTE_MASK;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         mcr_q <= '0;
    else if (mcr_snoop) mcr_q <= wdata;
  end

  for (genvar gi = 0; gi < NCHAR; gi++) begin : g_char
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        xon_q[gi]  <= '0;
        xoff_q[gi] <= '0;
      end else if (wr_en && (idx == 1'(gi))) begin
        if (tgt == TGT_XON)  xon_q[gi]  <= wdata;
        if (tgt == TGT_XOFF) xoff_q[gi] <= wdata;
      end
    end
  end

  always_comb begin
    case (tgt)
      TGT_EFR:  rd_val = efr_q;
      TGT_XON:  rd_val = xon_q[idx];
      TGT_XOFF: rd_val = xoff_q[idx];
      TGT_TCR:  rd_val = tcr_q;
      TGT_TLR:  rd_val = tlr_q;
      TGT_BLR:  rd_val = blr_q;
      TGT_ACR:  rd_val = acr_q;
      default:  rd_val = '0;
    endcase
  end

  assign efr_enh  = efr_q[EFR_ENH_BIT];
  assign mcr_trig = mcr_q[MCR_TRIG_BIT];

  AST_BLR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tgt == TGT_ZERO) |=> ($stable(blr_q) && $stable(acr_q))); // R6
  AST_BLR_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (blr_q & ~BLR_MASK) == '0); // R6
  AST_MCR_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !mcr_snoop |=> $stable(mcr_q)); // R9

endmodule

// File: rtl/uart_bank_decoder.sv
module uart_bank_decoder
  import uart_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              core_sel,
  output logic [ADDR_W-1:0] core_addr,
  output logic [DATA_W-1:0] core_wdata,
  output logic              core_we,
  output logic              core_re,
  input  logic [DATA_W-1:0] core_rdata
);

  localparam logic [ADDR_W-1:0] A_LCR = ADDR_W'(OFS_LCR);
  localparam logic [ADDR_W-1:0] A_MCR = ADDR_W'(OFS_MCR);
  localparam logic [ADDR_W-1:0] A_EFR = ADDR_W'(OFS_EFR);
  localparam logic [ADDR_W-1:0] A_TCR = ADDR_W'(OFS_TCR);
  localparam logic [ADDR_W-1:0] A_TLR = ADDR_W'(OFS_TLR);
  localparam logic [ADDR_W-1:0] A_BLR = ADDR_W'(OFS_BLR);

  acc_mode_e         mode;
  tgt_e              tgt;
  logic              idx;
  logic              efr_enh, mcr_trig;
  logic              is_core, lcr_wr, mcr_snoop;
  logic [DATA_W-1:0] local_rd;
  logic [DATA_W-1:0] rdata_q;

  assign lcr_wr    = bus_we && (bus_addr == A_LCR);
  assign mcr_snoop = bus_we && (bus_addr == A_MCR) && (mode != MODE_CFG_B);

  uart_bank_mode u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .lcr_wr   (lcr_wr),
    .lcr_byte (bus_wdata[7:0]),
    .mode     (mode)
  );

  uart_bank_route #(.ADDR_W(ADDR_W)) u_route (
    .addr     (bus_addr),
    .mode     (mode),
    .efr_enh  (efr_enh),
    .mcr_trig (mcr_trig),
    .tgt      (tgt),
    .idx      (idx)
  );

  uart_bank_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_we),
    .tgt       (tgt),
    .idx       (idx),
    .wdata     (bus_wdata),
    .mcr_snoop (mcr_snoop),
    .rd_val    (local_rd),
    .efr_enh   (efr_enh),
    .mcr_trig  (mcr_trig)
  );

  assign is_core    = (tgt == TGT_CORE);
  assign core_sel   = (bus_we || bus_re) && is_core;
  assign core_we    = bus_we && is_core;
  assign core_re    = bus_re && is_core;
  assign core_addr  = bus_addr;
  assign core_wdata = bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_re) rdata_q <= is_core ? core_rdata : local_rd;
  end

  assign bus_rdata = rdata_q;

  AST_LCR_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_LCR) |-> core_we); // R1
  AST_EFR_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CFG_B && (bus_we || bus_re) && bus_addr == A_EFR) |-> !core_sel); // R2
  AST_TRIG_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (efr_enh && mcr_trig && (bus_addr == A_TCR || bus_addr == A_TLR)) |-> !core_sel); // R4
  AST_CFG_BLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == A_BLR && mode != MODE_OP) |=> (bus_rdata == '0)); // R6
  AST_FWD_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && core_sel) |=> (bus_rdata == $past(core_rdata))); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata)); // R10

endmodule

// File: tb/uart_bank_decoder_tb.sv
module uart_bank_decoder_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic       bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic       core_sel, core_we, core_re;
  logic [7:0] core_addr, core_wdata, core_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign core_rdata = core_re ? (core_addr ^ 8'hA5) : 8'h00;

  uart_bank_decoder #(.ADDR_W(8), .DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .core_sel(core_sel), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_we(core_we), .core_re(core_re), .core_rdata(core_rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, output logic fwd);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_re = 1'b0;
    #1 fwd = core_we;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v, output logic fwd);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1; bus_we = 1'b0;
    #1 fwd = core_re;
    @(negedge clk);
    v = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic set_lcr(input logic [7:0] d);
    logic f;
    wr(8'h0C, d, f);
    chk("R1 lcr write forwarded", {7'd0, f}, 8'h01);
  endtask

  task automatic expect_local(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v; logic f;
    rd(a, v, f);
    chk({req, " local data"}, v, exp);
    chk({req, " not forwarded"}, {7'd0, f}, 8'h00);
  endtask

  task automatic expect_core(input string req, input logic [7:0] a);
    logic [7:0] v; logic f;
    rd(a, v, f);
    chk({req, " core data"}, v, a ^ 8'hA5);
    chk({req, " forwarded"}, {7'd0, f}, 8'h01);
  endtask

  task automatic wr_local(input string req, input logic [7:0] a, input logic [7:0] d);
    logic f;
    wr(a, d, f);
    chk({req, " write kept local"}, {7'd0, f}, 8'h00);
  endtask

  task automatic t_reset();
    chk("R8 rdata reset", bus_rdata, 8'h00);
    chk("R8 core_sel idle", {7'd0, core_sel}, 8'h00);
    expect_local("R8 blr reset", 8'h38, 8'h40);
    expect_local("R8 acr reset", 8'h3C, 8'h00);
    expect_core("R2 efr forwarded in op", 8'h08);
    expect_core("R11 offset 0x00", 8'h00);
    expect_core("R11 offset 0x04", 8'h04);
    expect_core("R11 offset 0x20", 8'h20);
    expect_core("R11 lcr read", 8'h0C);
  endtask

  task automatic t_lcr_modes();
    set_lcr(8'h80);
    expect_local("R1 mode A blr zero", 8'h38, 8'h00);
    expect_core("R1 mode A efr forwarded", 8'h08);
    set_lcr(8'hBF);
    expect_local("R1 mode B efr local (R8 zero)", 8'h08, 8'h00);
    set_lcr(8'hBE);
    expect_core("R1 0xBE is mode A", 8'h08);
    expect_local("R1 0xBE blr zero", 8'h38, 8'h00);
    set_lcr(8'h3F);
    expect_local("R1 0x3F is operational", 8'h38, 8'h40);
  endtask

  task automatic t_efr();
    set_lcr(8'hBF);
    wr_local("R2 efr", 8'h08, 8'h10);
    expect_local("R2 efr readback", 8'h08, 8'h10);
    set_lcr(8'h80);
    expect_core("R2 efr hidden in mode A", 8'h08);
  endtask

  task automatic t_xon();
    set_lcr(8'hBF);
    wr_local("R3 xon0", 8'h10, 8'h11);
    wr_local("R3 xon1", 8'h14, 8'h13);
    expect_local("R3 xon0 readback", 8'h10, 8'h11);
    expect_local("R3 xon1 readback", 8'h14, 8'h13);
    set_lcr(8'h00);
    expect_core("R3 0x14 forwarded in op", 8'h14);
  endtask

  task automatic t_xoff();
    set_lcr(8'hBF);
    wr_local("R5 xoff0", 8'h18, 8'h22);
    wr_local("R5 xoff1", 8'h1C, 8'h24);
    expect_local("R5 xoff0 readback", 8'h18, 8'h22);
    expect_local("R5 xoff1 readback", 8'h1C, 8'h24);
    set_lcr(8'h00);
    expect_core("R5 0x1C forwarded in op", 8'h1C);
  endtask

  task automatic t_overlay();
    logic f;
    set_lcr(8'h00);
    wr(8'h10, 8'h40, f);
    chk("R9 mcr write forwarded", {7'd0, f}, 8'h01);
    expect_local("R4 tcr reset R8", 8'h18, 8'h0F);
    wr_local("R4 tlr", 8'h1C, 8'h5A);
    expect_local("R4 tlr readback", 8'h1C, 8'h5A);
    set_lcr(8'hBF);
    expect_local("R4 tcr wins over mode B", 8'h18, 8'h0F);
    expect_local("R9 xon0 untouched by mcr", 8'h10, 8'h11);
    wr_local("R9 mode B 0x10", 8'h10, 8'h00);
    expect_local("R9 shadow kept in mode B", 8'h18, 8'h0F);
    expect_local("R9 mode B 0x10 went to xon0", 8'h10, 8'h00);
    set_lcr(8'h00);
    wr(8'h10, 8'h00, f);
    chk("R9 mcr clear forwarded", {7'd0, f}, 8'h01);
    set_lcr(8'hBF);
    expect_local("R5 xoff back after overlay off", 8'h18, 8'h22);
  endtask

  task automatic t_blr();
    set_lcr(8'h00);
    wr_local("R6 blr", 8'h38, 8'hFF);
    expect_local("R6 blr keeps 7:6", 8'h38, 8'hC0);
    set_lcr(8'h80);
    wr_local("R6 blr in mode A", 8'h38, 8'h00);
    expect_local("R6 blr zero in mode A", 8'h38, 8'h00);
    set_lcr(8'hBF);
    expect_local("R6 blr zero in mode B", 8'h38, 8'h00);
    set_lcr(8'h00);
    expect_local("R6 blr write dropped", 8'h38, 8'hC0);
  endtask

  task automatic t_acr();
    set_lcr(8'h00);
    wr_local("R7 acr", 8'h3C, 8'h5C);
    expect_local("R7 acr readback", 8'h3C, 8'h5C);
    set_lcr(8'hBF);
    wr_local("R7 acr in mode B", 8'h3C, 8'h00);
    expect_local("R7 acr zero in mode B", 8'h3C, 8'h00);
    set_lcr(8'h80);
    expect_local("R7 acr zero in mode A", 8'h3C, 8'h00);
    set_lcr(8'h00);
    expect_local("R7 acr write dropped", 8'h3C, 8'h5C);
  endtask

  task automatic t_latency();
    logic [7:0] v; logic f;
    rd(8'h24, v, f);
    chk("R10 forwarded read data", v, 8'h81);
    @(negedge clk);
    chk("R10 rdata holds", bus_rdata, 8'h81);
    chk("R10 core_sel idle", {7'd0, core_sel}, 8'h00);
    bus_addr = 8'h38; bus_re = 1'b1;
    #1 chk("R10 no change before edge", bus_rdata, 8'h81);
    @(negedge clk);
    chk("R10 local read after edge", bus_rdata, 8'hC0);
    bus_re = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lcr_modes();
    t_efr();
    t_xon();
    t_xoff();
    t_overlay();
    t_blr();
    t_acr();
    t_latency();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule